// File: doc/BRIEF.md
# Single-Cycle Multiplier With Signed Correction

This block is the multiply unit of a small microcontroller datapath. It forms the full 16-bit unsigned product of two 8-bit operands in one clock cycle and holds it in a pair of 8-bit product registers, one for the upper byte and one for the lower byte. One operand comes from the working register (`wreg_i`), and the other is supplied with the command on `opnd_i`.

Signed multiplication uses a second command, "fix". When the sign bit of `opnd_i` is set, the fix command subtracts `wreg_i` from the upper product byte, modulo 256. Software first multiplies A by B. It then issues fix with `wreg_i`=A and `opnd_i`=B, and a second fix with `wreg_i`=B and `opnd_i`=A. After these three cycles the product pair holds the two's-complement product of the signed operands.

The product bytes can be read at any time on `prod_hi` and `prod_lo`. They can be written directly when no command is active, so software can preload or clear them. The unit has no status-flag outputs, so a multiply cannot disturb any flag.

Top module: `hwmul_core`

## Requirements
- R1: One clock edge after `mul_cmd` is sampled high, {`prod_hi`,`prod_lo`} equals the 16-bit unsigned product `wreg_i` * `opnd_i`.
- R2: `prod_hi` carries product bits 15..8 and `prod_lo` carries bits 7..0. For example, 0xFF * 0xFF gives `prod_hi`=0xFE and `prod_lo`=0x01.
- R3: When `fix_cmd` is high, `mul_cmd` is low and `opnd_i` bit 7 is 1, `prod_hi` becomes (`prod_hi` - `wreg_i`) mod 256 on the next edge.
- R4: When `fix_cmd` is high, `mul_cmd` is low and `opnd_i` bit 7 is 0, `prod_hi` is unchanged.
- R5: A fix command never changes `prod_lo`.
- R6: A multiply followed by the two fix steps (`wreg_i`=A, `opnd_i`=B, then `wreg_i`=B, `opnd_i`=A) leaves the 16-bit two's-complement product of signed A and signed B in the product pair.
- R7: If `mul_cmd` and `fix_cmd` are high in the same cycle, only the multiply takes effect.
- R8: A synchronous active-high `rst` clears both product bytes to 0.
- R9: With no command active, `wr_hi` loads `wr_data` into `prod_hi` and `wr_lo` loads `wr_data` into `prod_lo`. Both may be asserted together.
- R10: A direct write (`wr_hi`/`wr_lo`) is ignored in any cycle where `mul_cmd` or `fix_cmd` is high.
- R11: With no command and no write, both product bytes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wreg_i | input | 8 | Working-register operand; the subtrahend for fix |
| opnd_i | input | 8 | Command operand; its bit 7 gates fix |
| mul_cmd | input | 1 | Multiply command |
| fix_cmd | input | 1 | Conditional subtract-from-high command |
| wr_hi | input | 1 | Direct write of the high product byte |
| wr_lo | input | 1 | Direct write of the low product byte |
| wr_data | input | 8 | Data for direct writes |
| prod_hi | output | 8 | High product byte |
| prod_lo | output | 8 | Low product byte |

## Verification
The hardest situation to reach is a fix step that acts on a genuinely negative operand while the upper byte is about to wrap. Only the right sequence reaches it: a multiply, then two fix steps with the operand roles swapped, each depending on the byte left by the step before. The bench therefore drives every unsigned operand pair once, with a multiply check after each. For a strided sweep covering all sign combinations it drives the full three-step sequence, checking the intermediate byte after each fix and the final signed product. Directed cycles then collide the commands with each other and with writes.

// File: rtl/hwmul_pkg.sv
package hwmul_pkg;
    localparam int DW = 8;
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } prod_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_MUL  = 2'd1,
        OP_FIX  = 2'd2,
        OP_LOAD = 2'd3
    } op_e;

    // multiply outranks fix, and any command outranks a direct write
    function automatic op_e pick_op(input logic mul, input logic fix,
                                    input logic whi, input logic wlo);
        if (mul)
            return OP_MUL;
        else if (fix)
            return OP_FIX;
        else if (whi || wlo)
            return OP_LOAD;
        return OP_IDLE;
    endfunction

    function automatic prod_t split_prod(input logic [PW-1:0] p);
        prod_t r;
        r.hi = p[PW-1:DW];
        r.lo = p[DW-1:0];
        return r;
    endfunction
endpackage

// File: rtl/hwmul_array.sv
module hwmul_array
    import hwmul_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [PW-1:0] p_o
);
    logic [PW-1:0] pp [DW];

    for (genvar g = 0; g < DW; g++) begin : g_row
        assign pp[g] = b_i[g] ? (PW'(a_i) << g) : '0;
    end

    always_comb begin
        p_o = '0;
        for (int k = 0; k < DW; k++)
            p_o = p_o + pp[k];
    end
endmodule

// File: rtl/hwmul_fix.sv
module hwmul_fix
    import hwmul_pkg::*;
(
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] sub_i,
    input  logic [DW-1:0] sgn_src_i,
    output logic [DW-1:0] hi_o
);
    always_comb begin
        if (sgn_src_i[DW-1])
            hi_o = hi_i - sub_i;
        else
            hi_o = hi_i;
    end
endmodule

// File: rtl/hwmul_prodreg.sv
module hwmul_prodreg
    import hwmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  prod_t         mul_val,
    input  logic [DW-1:0] fix_hi,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [DW-1:0] wr_data,
    output prod_t         q
);
    prod_t nxt;

    always_comb begin
        nxt = q;
        case (op)
            OP_MUL: nxt = mul_val;
            OP_FIX: nxt.hi = fix_hi;
            OP_LOAD: begin
                if (wr_hi) nxt.hi = wr_data;
                if (wr_lo) nxt.lo = wr_data;
            end
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    // R5
    fix_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FIX) |=> (q.lo == $past(q.lo)));
endmodule

// File: rtl/hwmul_core.sv
module hwmul_core
    import hwmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wreg_i,
    input  logic [DW-1:0] opnd_i,
    input  logic          mul_cmd,
    input  logic          fix_cmd,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] prod_hi,
    output logic [DW-1:0] prod_lo
);
    logic [PW-1:0] raw_prod;
    logic [DW-1:0] fixed_hi;
    prod_t         state;
    op_e           op;

    assign op = pick_op(mul_cmd, fix_cmd, wr_hi, wr_lo);

    hwmul_array u_array (
        .a_i (wreg_i),
        .b_i (opnd_i),
        .p_o (raw_prod)
    );

    hwmul_fix u_fix (
        .hi_i      (state.hi),
        .sub_i     (wreg_i),
        .sgn_src_i (opnd_i),
        .hi_o      (fixed_hi)
    );

    hwmul_prodreg u_reg (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .mul_val (split_prod(raw_prod)),
        .fix_hi  (fixed_hi),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .q       (state)
    );

    assign prod_hi = state.hi;
    assign prod_lo = state.lo;

    // R1
    mul_result_chk: assert property (@(posedge clk) disable iff (rst)
        mul_cmd |=> ({prod_hi, prod_lo} == PW'($past(wreg_i)) * PW'($past(opnd_i))));

    // R4
    fix_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (fix_cmd && !mul_cmd && !opnd_i[DW-1]) |=> $stable(prod_hi));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mul_cmd && !fix_cmd && !wr_hi && !wr_lo) |=> ($stable(prod_hi) && $stable(prod_lo)));

    // R10
    write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (fix_cmd && !mul_cmd && wr_lo) |=> $stable(prod_lo));
endmodule

// File: tb/hwmul_core_tb.sv
module hwmul_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] wreg_i = '0, opnd_i = '0, wr_data = '0;
    logic       mul_cmd = 1'b0, fix_cmd = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
    logic [7:0] prod_hi, prod_lo;

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] hi;
        logic [7:0] lo;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] ref_hi = '0, ref_lo = '0;
    int total = 0, bad = 0, cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hwmul_core u_dut (
        .clk(clk), .rst(rst), .wreg_i(wreg_i), .opnd_i(opnd_i),
        .mul_cmd(mul_cmd), .fix_cmd(fix_cmd), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic pulse_reset(input int req);
        @(negedge clk);
        rst = 1'b1; mul_cmd = 0; fix_cmd = 0; wr_hi = 0; wr_lo = 0;
        ref_hi = '0; ref_lo = '0;
        exp_q.push_back('{req: 8'(req), hi: ref_hi, lo: ref_lo});
    endtask

    // drive one cycle; expected state follows the requirement rules
    task automatic step(input logic m, input logic f, input logic wh, input logic wl,
                        input logic [7:0] w, input logic [7:0] o, input logic [7:0] d,
                        input int req, input bit use_exp, input logic [15:0] exp_v);
        logic [15:0] p;
        @(negedge clk);
        rst = 1'b0; mul_cmd = m; fix_cmd = f; wr_hi = wh; wr_lo = wl;
        wreg_i = w; opnd_i = o; wr_data = d;
        if (m) begin
            p = 16'(w) * 16'(o);
            ref_hi = p[15:8]; ref_lo = p[7:0];
        end else if (f) begin
            if (o[7]) ref_hi = ref_hi - w;
        end else begin
            if (wh) ref_hi = d;
            if (wl) ref_lo = d;
        end
        if (use_exp) begin
            ref_hi = exp_v[15:8]; ref_lo = exp_v[7:0];
        end
        exp_q.push_back('{req: 8'(req), hi: ref_hi, lo: ref_lo});
    endtask

    task automatic idle(input int req);
        step(0, 0, 0, 0, 8'h00, 8'h00, 8'h00, req, 0, 16'h0);
    endtask

    // monitor: compares each queued item one step after its edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                total++;
                if (prod_hi !== e.hi || prod_lo !== e.lo) begin
                    bad++;
                    $display("FAIL R%0d: got %02h%02h expected %02h%02h",
                             e.req, prod_hi, prod_lo, e.hi, e.lo);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] sp;
        pulse_reset(8);
        step(0, 0, 1, 1, 8'h00, 8'h00, 8'h5A, 9, 0, 16'h0);        // R9 both bytes
        pulse_reset(8);                                              // R8 clears preload
        step(0, 0, 1, 0, 8'h00, 8'h00, 8'hA5, 9, 0, 16'h0);        // R9 high only
        step(0, 0, 0, 1, 8'h00, 8'h00, 8'h3C, 9, 0, 16'h0);        // R9 low only
        idle(11);                                                    // R11
        idle(11);
        step(1, 0, 0, 0, 8'hFF, 8'hFF, 8'h00, 2, 1, 16'hFE01);     // R2
        step(1, 0, 0, 0, 8'h12, 8'h34, 8'h00, 2, 1, 16'h03A8);     // R2
        step(0, 1, 0, 0, 8'h10, 8'h80, 8'h00, 3, 1, 16'hF3A8);     // R3 wraps
        step(0, 1, 0, 0, 8'h10, 8'h7F, 8'h00, 4, 0, 16'h0);        // R4
        step(0, 1, 0, 0, 8'hFF, 8'hFF, 8'h00, 5, 0, 16'h0);        // R5 lo kept
        step(1, 1, 0, 0, 8'h03, 8'h85, 8'h00, 7, 1, 16'h018F);     // R7
        step(1, 0, 1, 1, 8'h02, 8'h02, 8'hEE, 10, 1, 16'h0004);    // R10 with mul
        step(0, 1, 1, 1, 8'h01, 8'h80, 8'hEE, 10, 1, 16'hFF04);    // R10 with fix
        // R1 exhaustive unsigned sweep
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(1, 0, 0, 0, 8'(a), 8'(b), 8'h00, 1, 0, 16'h0);
        // R6 signed sequence, strided second operand
        for (int a = 0; a < 256; a++)
            for (int b = 1; b < 256; b += 4) begin
                sp = 16'($signed(8'(a)) * $signed(8'(b)));
                step(1, 0, 0, 0, 8'(a), 8'(b), 8'h00, 1, 0, 16'h0);
                step(0, 1, 0, 0, 8'(a), 8'(b), 8'h00, 3, 0, 16'h0);
                step(0, 1, 0, 0, 8'(b), 8'(a), 8'h00, 6, 1, sp);
            end
        pulse_reset(8);                                              // R8 after activity
        idle(11);
        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule